// File: doc/BRIEF.md
# Debug Module Register Front-End

This block is the register file that an external debugger reaches over a debug transport link. The link issues one 32-bit read or write per request, addressed by a 7-bit register number. One cycle later the block answers with the read data and an error flag. The register file holds:

- a control word that selects a hart and carries halt, resume and system-reset requests;
- a status word computed for the selected hart;
- an abstract-command status word;
- a pair of auto-execute masks;
- two small arrays: data words and program-buffer words.

A write to the command register stores a command word, checks it, and launches it on the selected hart. The launch is a one-cycle go pulse. The hart reports completion with a done pulse.

While a command is in flight the data and program-buffer arrays are locked. A data-word access in that window leaves a sticky busy error. When the block is idle, a data or program-buffer access whose auto-execute bit is set launches the stored command again. A debugger can therefore stream a block of transfers with plain data accesses.

Top module: `dbg_regfront`

## Requirements
- R1: Every request cycle produces exactly one response cycle (`rsp_valid_o` high) on the following cycle, carrying `rdata_o` and `rsp_err_o`. No response appears without a request.
- R2: Writing the control word with bit 0 (activate) at 0 returns these to zero: control fields, busy, error code, auto-execute masks and stored command.
- R3: Writing control with bit 0 at 1 loads these fields: halt request (bit 31), resume request (bit 30), hart select (bits 25:16) and system reset (bit 1). Control reads back in the same layout. `halt_req_o` is high only for the selected hart, and `ndmreset_o` follows bit 1.
- R4: The status word (address 0x11) always holds version 2 in bits 3:0 and a 1 in bit 7. For the selected hart, bits 9:8 read 11 when it is halted and bits 11:10 read 11 when it runs. When hart select is at or beyond the hart count, bits 15:14 read 11 instead and the halted/running bits are 0.
- R5: A control write with resume request set and a valid hart selected raises that hart's `resume_req_o` and clears its resume-ack flag. A `hart_resume_ack_i` pulse from that hart drops the request and sets the flag. The flag reads in status bits 17:16.
- R6: A command word (address 0x17) is checked in this order:
  - the error code is not none: it is ignored;
  - bits 31:24 are nonzero: error 2;
  - the selected hart is not halted or does not exist: error 4;
  - bit 17 (transfer) is set with a register number (bits 15:0) outside 0x1000..0x101F, or a size (bits 22:20) other than 2 or 3: error 2.
- R7: A command that passes R6 sets busy (command-status bit 12) and pulses `cmd_go_o` for the selected hart for one cycle. Busy clears only on a `hart_cmd_done_i` pulse from that same hart.
- R8: The error code, in command-status bits 10:8, is write-one-to-clear: each 1 written clears that bit, each 0 leaves it.
- R9: While busy, a data-word read returns 0xFFFFFFFF and a data-word write is ignored. Either access sets the error code to 1 (busy) if it was 0.
- R10: While busy, program-buffer writes are ignored and reads return 0xFFFFFFFF, with no error code change.
- R11: While idle, an access to data word i whose bit i is set in auto-execute bits 11:0 launches the stored command again. The same holds for program-buffer word j whose bit 16+j is set in auto-execute bits 31:16.
- R12: The command register reads as 0. Command status reports the data count in bits 3:0 and the program-buffer size in bits 28:24. An unmapped address, or a write to status, answers with `rsp_err_o` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Register access request |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 7 | Register address |
| wdata_i | input | 32 | Write data |
| rsp_valid_o | output | 1 | Response valid, one cycle after request |
| rdata_o | output | 32 | Read data |
| rsp_err_o | output | 1 | Access error |
| hart_halted_i | input | NHART | Per-hart halted level |
| hart_resume_ack_i | input | NHART | Per-hart resume acknowledge pulse |
| hart_cmd_done_i | input | NHART | Per-hart command completion pulse |
| halt_req_o | output | NHART | Halt request to the selected hart |
| resume_req_o | output | NHART | Pending resume request per hart |
| ndmreset_o | output | 1 | System reset request |
| cmd_go_o | output | NHART | One-cycle command launch pulse per hart |
| cmd_word_o | output | 32 | Stored command word |

## Verification
The bench builds the block with its defaults: four harts, two data words and two program-buffer words. With four harts a hart select of 5 reaches the nonexistent-hart status. It also lets a done pulse come from a hart other than the one that owns the command, which must leave busy set. With two words in each array, one word of each array can carry an auto-execute bit while its neighbour does not, so the bench can show that only the masked words relaunch.

// File: rtl/dbg_regfront_pkg.sv
package dbg_regfront_pkg;

  // abstract command error codes
  typedef enum logic [2:0] {
    ERR_NONE    = 3'd0,
    ERR_BUSY    = 3'd1,
    ERR_NOSUP   = 3'd2,
    ERR_EXC     = 3'd3,
    ERR_HALTRES = 3'd4,
    ERR_BUS     = 3'd5,
    ERR_OTHER   = 3'd7
  } cmderr_e;

  localparam logic [6:0] A_DATA0 = 7'h04;
  localparam logic [6:0] A_CTRL  = 7'h10;
  localparam logic [6:0] A_STAT  = 7'h11;
  localparam logic [6:0] A_ACS   = 7'h16;
  localparam logic [6:0] A_CMD   = 7'h17;
  localparam logic [6:0] A_AUTO  = 7'h18;
  localparam logic [6:0] A_PROG0 = 7'h20;

  localparam logic [3:0] SPEC_VERSION = 4'd2;
  localparam int         SEL_W        = 10;

endpackage

// File: rtl/dbg_hartctl.sv
module dbg_hartctl
  import dbg_regfront_pkg::*;
#(
  parameter int NHART  = 4,
  parameter int HIDX_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_wr,
  input  logic              wr_active,
  input  logic              wr_halt,
  input  logic              wr_resume,
  input  logic              wr_ndm,
  input  logic [SEL_W-1:0]  wr_sel,
  input  logic [NHART-1:0]  hart_halted_i,
  input  logic [NHART-1:0]  hart_rack_i,
  output logic [31:0]       ctl_rd,
  output logic [31:0]       stat_rd,
  output logic [HIDX_W-1:0] sel_idx,
  output logic              sel_halted,
  output logic [NHART-1:0]  halt_req_o,
  output logic [NHART-1:0]  resume_req_o,
  output logic              ndmreset_o
);

  logic             active_q, active_d;
  logic             halt_q, halt_d;
  logic             res_q, res_d;
  logic             ndm_q, ndm_d;
  logic [SEL_W-1:0] hsel_q, hsel_d;
  logic [NHART-1:0] pend_q, pend_d;
  logic [NHART-1:0] rack_q, rack_d;
  logic             sel_valid;
  logic             sel_rack;
  logic             sel_run;

  always_comb begin
    active_d = active_q;
    halt_d   = halt_q;
    res_d    = res_q;
    ndm_d    = ndm_q;
    hsel_d   = hsel_q;
    pend_d   = pend_q;
    rack_d   = rack_q;
    if (ctl_wr) begin
      active_d = wr_active;
      halt_d   = wr_active & wr_halt;
      res_d    = wr_active & wr_resume;
      ndm_d    = wr_active & wr_ndm;
      hsel_d   = wr_active ? wr_sel : '0;
    end
    for (int h = 0; h < NHART; h++) begin
      if (hart_rack_i[h]) begin
        pend_d[h] = 1'b0;
        rack_d[h] = 1'b1;
      end
      if (ctl_wr && wr_active && wr_resume && (wr_sel == SEL_W'(h))) begin
        pend_d[h] = 1'b1;
        rack_d[h] = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      halt_q   <= 1'b0;
      res_q    <= 1'b0;
      ndm_q    <= 1'b0;
      hsel_q   <= '0;
      pend_q   <= '0;
      rack_q   <= '0;
    end else begin
      active_q <= active_d;
      halt_q   <= halt_d;
      res_q    <= res_d;
      ndm_q    <= ndm_d;
      hsel_q   <= hsel_d;
      pend_q   <= pend_d;
      rack_q   <= rack_d;
    end
  end

  assign sel_valid  = hsel_q < SEL_W'(NHART);
  assign sel_idx    = hsel_q[HIDX_W-1:0];
  assign sel_halted = sel_valid && hart_halted_i[sel_idx];
  assign sel_run    = sel_valid && !hart_halted_i[sel_idx];
  assign sel_rack   = sel_valid && rack_q[sel_idx];

  generate
    for (genvar h = 0; h < NHART; h++) begin : g_halt
      assign halt_req_o[h] = halt_q && (hsel_q == SEL_W'(h));
    end
  endgenerate

  assign resume_req_o = pend_q;
  assign ndmreset_o   = ndm_q;

  assign ctl_rd  = {halt_q, res_q, 4'b0, hsel_q, 14'b0, ndm_q, active_q};
  assign stat_rd = {14'b0, sel_rack, sel_rack, !sel_valid, !sel_valid, 2'b00,
                    sel_run, sel_run, sel_halted, sel_halted, 1'b1, 3'b0,
                    SPEC_VERSION};

endmodule

// File: rtl/dbg_cmdeng.sv
module dbg_cmdeng
  import dbg_regfront_pkg::*;
#(
  parameter int NHART  = 4,
  parameter int DATA_N = 2,
  parameter int PROG_N = 2,
  parameter int HIDX_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              cmd_wr,
  input  logic              cs_wr,
  input  logic              auto_wr,
  input  logic              relaunch,
  input  logic              busy_err,
  input  logic [31:0]       wdata,
  input  logic [HIDX_W-1:0] sel_idx,
  input  logic              sel_halted,
  input  logic [NHART-1:0]  hart_done_i,
  output logic              busy,
  output logic [2:0]        cmderr,
  output logic [DATA_N-1:0] auto_data,
  output logic [PROG_N-1:0] auto_prog,
  output logic [NHART-1:0]  cmd_go_o,
  output logic [31:0]       cmd_word_o,
  output logic [31:0]       acs_rd,
  output logic [31:0]       auto_rd
);

  logic              busy_q, busy_d;
  cmderr_e           err_q, err_d;
  logic [HIDX_W-1:0] own_q, own_d;
  logic [31:0]       cmd_q, cmd_d;
  logic [DATA_N-1:0] ad_q, ad_d;
  logic [PROG_N-1:0] ap_q, ap_d;
  logic [NHART-1:0]  go_q, go_d;
  logic [31:0]       cmd_eval;
  logic              launch;
  logic              bad_xfer;

  assign cmd_eval = cmd_wr ? wdata : cmd_q;
  assign launch   = cmd_wr | relaunch;
  assign bad_xfer = cmd_eval[17] &&
                    ((cmd_eval[15:0] < 16'h1000) || (cmd_eval[15:0] > 16'h101F) ||
                     ((cmd_eval[22:20] != 3'd2) && (cmd_eval[22:20] != 3'd3)));

  always_comb begin
    busy_d = busy_q;
    err_d  = err_q;
    own_d  = own_q;
    cmd_d  = cmd_q;
    ad_d   = ad_q;
    ap_d   = ap_q;
    go_d   = '0;
    if (busy_q && hart_done_i[own_q]) busy_d = 1'b0;
    if (clear) begin
      busy_d = 1'b0;
      err_d  = ERR_NONE;
      cmd_d  = '0;
      ad_d   = '0;
      ap_d   = '0;
    end else begin
      if (cmd_wr) cmd_d = wdata;
      if (cs_wr) err_d = cmderr_e'(err_q & ~wdata[10:8]);
      if (auto_wr) begin
        ad_d = wdata[DATA_N-1:0];
        ap_d = wdata[16 +: PROG_N];
      end
      if (busy_err && (err_q == ERR_NONE)) err_d = ERR_BUSY;
      if (launch && (err_q == ERR_NONE)) begin
        if (busy_q)                     err_d = ERR_BUSY;
        else if (cmd_eval[31:24] != '0) err_d = ERR_NOSUP;
        else if (!sel_halted)           err_d = ERR_HALTRES;
        else if (bad_xfer)              err_d = ERR_NOSUP;
        else begin
          busy_d        = 1'b1;
          own_d         = sel_idx;
          go_d[sel_idx] = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      err_q  <= ERR_NONE;
      own_q  <= '0;
      cmd_q  <= '0;
      ad_q   <= '0;
      ap_q   <= '0;
      go_q   <= '0;
    end else begin
      busy_q <= busy_d;
      err_q  <= err_d;
      own_q  <= own_d;
      cmd_q  <= cmd_d;
      ad_q   <= ad_d;
      ap_q   <= ap_d;
      go_q   <= go_d;
    end
  end

  assign busy       = busy_q;
  assign cmderr     = err_q;
  assign auto_data  = ad_q;
  assign auto_prog  = ap_q;
  assign cmd_go_o   = go_q;
  assign cmd_word_o = cmd_q;
  assign acs_rd     = {3'b0, 5'(PROG_N), 11'b0, busy_q, 1'b0, err_q, 4'b0, 4'(DATA_N)};
  assign auto_rd    = {{(16-PROG_N){1'b0}}, ap_q, {(16-DATA_N){1'b0}}, ad_q};

endmodule

// File: rtl/dbg_bufarr.sv
module dbg_bufarr #(
  parameter int NWORD = 2,
  parameter int IDX_W = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] idx,
  input  logic [31:0]      wdata,
  output logic [31:0]      rd_data
);

  logic [31:0] mem_q [NWORD];

  generate
    for (genvar w = 0; w < NWORD; w++) begin : g_word
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mem_q[w] <= '0;
        else if (wr_en && (idx == IDX_W'(w))) mem_q[w] <= wdata;
      end
    end
  endgenerate

  assign rd_data = mem_q[idx];

endmodule

// File: rtl/dbg_regfront.sv
module dbg_regfront
  import dbg_regfront_pkg::*;
#(
  parameter int NHART  = 4,
  parameter int DATA_N = 2,
  parameter int PROG_N = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [6:0]        addr_i,
  input  logic [31:0]       wdata_i,
  output logic              rsp_valid_o,
  output logic [31:0]       rdata_o,
  output logic              rsp_err_o,
  input  logic [NHART-1:0]  hart_halted_i,
  input  logic [NHART-1:0]  hart_resume_ack_i,
  input  logic [NHART-1:0]  hart_cmd_done_i,
  output logic [NHART-1:0]  halt_req_o,
  output logic [NHART-1:0]  resume_req_o,
  output logic              ndmreset_o,
  output logic [NHART-1:0]  cmd_go_o,
  output logic [31:0]       cmd_word_o
);

  localparam int HIDX_W = (NHART  > 1) ? $clog2(NHART)  : 1;
  localparam int DIDX_W = (DATA_N > 1) ? $clog2(DATA_N) : 1;
  localparam int PIDX_W = (PROG_N > 1) ? $clog2(PROG_N) : 1;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_n;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= 2'b00;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n = rst_sync_q[1];

  logic [6:0]        off_d, off_p;
  logic              is_data, is_prog;
  logic [DIDX_W-1:0] didx;
  logic [PIDX_W-1:0] pidx;
  logic [31:0]       rd, ctl_rd, stat_rd, acs_rd, auto_rd, data_rd, prog_rd;
  logic              err, dwr, pwr, ctl_wr, cs_wr, cmd_wr, auto_wr, relaunch, busy_err;
  logic              busy, sel_halted;
  logic [2:0]        cmderr;
  logic [HIDX_W-1:0] sel_idx;
  logic [DATA_N-1:0] auto_data;
  logic [PROG_N-1:0] auto_prog;

  assign off_d   = addr_i - A_DATA0;
  assign off_p   = addr_i - A_PROG0;
  assign is_data = (addr_i >= A_DATA0) && (off_d < 7'(DATA_N));
  assign is_prog = (addr_i >= A_PROG0) && (off_p < 7'(PROG_N));
  assign didx    = off_d[DIDX_W-1:0];
  assign pidx    = off_p[PIDX_W-1:0];

  always_comb begin
    rd       = '0;
    err      = 1'b0;
    dwr      = 1'b0;
    pwr      = 1'b0;
    ctl_wr   = 1'b0;
    cs_wr    = 1'b0;
    cmd_wr   = 1'b0;
    auto_wr  = 1'b0;
    relaunch = 1'b0;
    busy_err = 1'b0;
    if (req_i) begin
      if (is_data) begin
        if (busy) begin
          rd       = '1;
          busy_err = 1'b1;
        end else begin
          rd       = data_rd;
          dwr      = we_i;
          relaunch = auto_data[didx];
        end
      end else if (is_prog) begin
        if (busy) begin
          rd = '1;
        end else begin
          rd       = prog_rd;
          pwr      = we_i;
          relaunch = auto_prog[pidx];
        end
      end else begin
        unique case (addr_i)
          A_CTRL: begin rd = ctl_rd;  ctl_wr  = we_i; end
          A_STAT: begin rd = stat_rd; err     = we_i; end
          A_ACS:  begin rd = acs_rd;  cs_wr   = we_i; end
          A_CMD:  begin               cmd_wr  = we_i; end
          A_AUTO: begin rd = auto_rd; auto_wr = we_i; end
          default: err = 1'b1;
        endcase
      end
    end
  end

  dbg_hartctl #(.NHART(NHART), .HIDX_W(HIDX_W)) u_hartctl (
    .clk          (clk_i),
    .rst_n        (rst_n),
    .ctl_wr       (ctl_wr),
    .wr_active    (wdata_i[0]),
    .wr_halt      (wdata_i[31]),
    .wr_resume    (wdata_i[30]),
    .wr_ndm       (wdata_i[1]),
    .wr_sel       (wdata_i[25:16]),
    .hart_halted_i(hart_halted_i),
    .hart_rack_i  (hart_resume_ack_i),
    .ctl_rd       (ctl_rd),
    .stat_rd      (stat_rd),
    .sel_idx      (sel_idx),
    .sel_halted   (sel_halted),
    .halt_req_o   (halt_req_o),
    .resume_req_o (resume_req_o),
    .ndmreset_o   (ndmreset_o)
  );

  dbg_cmdeng #(.NHART(NHART), .DATA_N(DATA_N), .PROG_N(PROG_N), .HIDX_W(HIDX_W)) u_cmdeng (
    .clk        (clk_i),
    .rst_n      (rst_n),
    .clear      (ctl_wr && !wdata_i[0]),
    .cmd_wr     (cmd_wr),
    .cs_wr      (cs_wr),
    .auto_wr    (auto_wr),
    .relaunch   (relaunch),
    .busy_err   (busy_err),
    .wdata      (wdata_i),
    .sel_idx    (sel_idx),
    .sel_halted (sel_halted),
    .hart_done_i(hart_cmd_done_i),
    .busy       (busy),
    .cmderr     (cmderr),
    .auto_data  (auto_data),
    .auto_prog  (auto_prog),
    .cmd_go_o   (cmd_go_o),
    .cmd_word_o (cmd_word_o),
    .acs_rd     (acs_rd),
    .auto_rd    (auto_rd)
  );

  dbg_bufarr #(.NWORD(DATA_N), .IDX_W(DIDX_W)) u_data (
    .clk(clk_i), .rst_n(rst_n), .wr_en(dwr), .idx(didx), .wdata(wdata_i), .rd_data(data_rd)
  );

  dbg_bufarr #(.NWORD(PROG_N), .IDX_W(PIDX_W)) u_prog (
    .clk(clk_i), .rst_n(rst_n), .wr_en(pwr), .idx(pidx), .wdata(wdata_i), .rd_data(prog_rd)
  );

  logic        rsp_v_q;
  logic [31:0] rdata_q;
  logic        err_q;
  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      rsp_v_q <= 1'b0;
      rdata_q <= '0;
      err_q   <= 1'b0;
    end else begin
      rsp_v_q <= req_i;
      if (req_i) begin
        rdata_q <= rd;
        err_q   <= err;
      end
    end
  end

  assign rsp_valid_o = rsp_v_q;
  assign rdata_o     = rdata_q;
  assign rsp_err_o   = err_q;

endmodule

// File: rtl/dbg_regfront_chk.sv
module dbg_regfront_chk #(
  parameter int NHART = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req,
  input logic             we,
  input logic [6:0]       addr,
  input logic [31:0]      wdata,
  input logic             rsp_valid,
  input logic [31:0]      rdata,
  input logic             rsp_err,
  input logic [NHART-1:0] halt_req,
  input logic [NHART-1:0] cmd_go,
  input logic             busy,
  input logic [2:0]       cmderr
);

  // R1
  rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req |=> rsp_valid);

  // R1
  no_stray_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req |=> !rsp_valid);

  // R3
  halt_one_hart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(halt_req));

  // R7
  go_while_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_go != '0) |-> busy);

  // R7
  go_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cmd_go));

  // R8
  w1c_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req && we && addr == 7'h16 && wdata[10:8] == 3'b111) |=> (cmderr == 3'd0));

  // R9
  busy_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req && addr == 7'h04 && busy && cmderr == 3'd0) |=> (cmderr == 3'd1));

  // R9
  busy_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !we && addr == 7'h04 && busy) |=> (rdata == 32'hFFFF_FFFF));

  // R12
  cmd_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !we && addr == 7'h17) |=> (rdata == 32'h0 && !rsp_err));

  // R12
  unmapped_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req && addr == 7'h7F) |=> rsp_err);

endmodule

bind dbg_regfront dbg_regfront_chk #(.NHART(NHART)) i_chk (
  .clk      (clk_i),
  .rst_n    (rst_n),
  .req      (req_i),
  .we       (we_i),
  .addr     (addr_i),
  .wdata    (wdata_i),
  .rsp_valid(rsp_valid_o),
  .rdata    (rdata_o),
  .rsp_err  (rsp_err_o),
  .halt_req (halt_req_o),
  .cmd_go   (cmd_go_o),
  .busy     (busy),
  .cmderr   (cmderr)
);

// File: tb/test_dbg_regfront.sv
`timescale 1ns/1ps
module test_dbg_regfront;

  localparam int NH = 4;

  logic          clk = 1'b0;
  logic          rst_ni;
  logic          req, we;
  logic [6:0]    addr;
  logic [31:0]   wdata;
  logic          rsp_valid, rsp_err, ndmreset;
  logic [31:0]   rdata, cmd_word;
  logic [NH-1:0] halted, rack, done, halt_req, resume_req, cmd_go;

  int            n_run = 0;
  int            n_fail = 0;
  logic [31:0]   r_data;
  logic          r_err;
  logic [NH-1:0] r_go;

  always #5 clk = ~clk;

  dbg_regfront i_dbg_regfront (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req), .we_i(we), .addr_i(addr), .wdata_i(wdata),
    .rsp_valid_o(rsp_valid), .rdata_o(rdata), .rsp_err_o(rsp_err),
    .hart_halted_i(halted), .hart_resume_ack_i(rack), .hart_cmd_done_i(done),
    .halt_req_o(halt_req), .resume_req_o(resume_req), .ndmreset_o(ndmreset),
    .cmd_go_o(cmd_go), .cmd_word_o(cmd_word)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic acc(input logic w, input logic [6:0] a, input logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = w; addr = a; wdata = d;
    @(negedge clk);
    chk("R1 rsp_valid", {31'b0, rsp_valid}, 32'd1);
    r_data = rdata; r_err = rsp_err; r_go = cmd_go;
    req = 1'b0; we = 1'b0;
  endtask

  task automatic wr(input logic [6:0] a, input logic [31:0] d);
    acc(1'b1, a, d);
  endtask

  task automatic rd_chk(input string tag, input logic [6:0] a, input logic [31:0] exp);
    acc(1'b0, a, 32'h0);
    chk(tag, r_data, exp);
  endtask

  task automatic pulse_done(input int h);
    @(negedge clk); done[h] = 1'b1;
    @(negedge clk); done = '0;
  endtask

  task automatic pulse_rack(input int h);
    @(negedge clk); rack[h] = 1'b1;
    @(negedge clk); rack = '0;
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R1 idle no rsp", {31'b0, rsp_valid}, 32'd0);
    rd_chk("R3 control reset", 7'h10, 32'h0);
    rd_chk("R4 status reset", 7'h11, 32'h0000_0C82);
    rd_chk("R12 acs constants", 7'h16, 32'h0200_0002);
    chk("R3 no halt", {28'b0, halt_req}, 32'h0);
  endtask

  task automatic t_control();
    wr(7'h10, 32'h8002_0001);
    chk("R3 write ok", {31'b0, r_err}, 32'd0);
    chk("R3 halt to hart2", {28'b0, halt_req}, 32'h4);
    rd_chk("R3 control readback", 7'h10, 32'h8002_0001);
    wr(7'h10, 32'h0002_0003);
    chk("R3 ndmreset", {31'b0, ndmreset}, 32'd1);
    chk("R3 halt dropped", {28'b0, halt_req}, 32'h0);
    wr(7'h18, 32'h0001_0003);
    wr(7'h10, 32'h0);
    rd_chk("R2 control cleared", 7'h10, 32'h0);
    chk("R2 ndmreset cleared", {31'b0, ndmreset}, 32'd0);
    rd_chk("R2 autoexec cleared", 7'h18, 32'h0);
  endtask

  task automatic t_status();
    halted = 4'b0010;
    wr(7'h10, 32'h0001_0001);
    rd_chk("R4 halted hart", 7'h11, 32'h0000_0382);
    wr(7'h10, 32'h0005_0001);
    rd_chk("R4 nonexistent hart", 7'h11, 32'h0000_C082);
    wr(7'h10, 32'h0000_0001);
    rd_chk("R4 running hart", 7'h11, 32'h0000_0C82);
  endtask

  task automatic t_resume();
    wr(7'h10, 32'h4001_0001);
    chk("R5 resume pending", {28'b0, resume_req}, 32'h2);
    rd_chk("R5 ack clear", 7'h11, 32'h0000_0382);
    pulse_rack(1);
    chk("R5 resume dropped", {28'b0, resume_req}, 32'h0);
    rd_chk("R5 ack set", 7'h11, 32'h0003_0382);
    wr(7'h10, 32'h4001_0001);
    rd_chk("R5 ack cleared again", 7'h11, 32'h0000_0382);
    pulse_rack(1);
  endtask

  task automatic t_cmd_err();
    wr(7'h10, 32'h0001_0001);
    wr(7'h17, 32'h0100_0000);
    rd_chk("R6 bad type", 7'h16, 32'h0200_0202);
    wr(7'h16, 32'h0000_0100);
    rd_chk("R8 zero bits keep", 7'h16, 32'h0200_0202);
    wr(7'h16, 32'h0000_0200);
    rd_chk("R8 one bit clears", 7'h16, 32'h0200_0002);
    wr(7'h10, 32'h0000_0001);
    wr(7'h17, 32'h0000_0000);
    rd_chk("R6 hart not halted", 7'h16, 32'h0200_0402);
    wr(7'h17, 32'h0100_0000);
    rd_chk("R6 error blocks", 7'h16, 32'h0200_0402);
    wr(7'h16, 32'h0000_0700);
    wr(7'h10, 32'h0001_0001);
    wr(7'h17, 32'h0022_2000);
    rd_chk("R6 bad regno", 7'h16, 32'h0200_0202);
    wr(7'h16, 32'h0000_0700);
    wr(7'h17, 32'h0042_1005);
    rd_chk("R6 bad size", 7'h16, 32'h0200_0202);
    wr(7'h16, 32'h0000_0700);
  endtask

  task automatic t_busy();
    wr(7'h04, 32'hA5A5_0001);
    wr(7'h20, 32'h0000_0013);
    wr(7'h17, 32'h0022_1005);
    chk("R7 go to hart1", {28'b0, r_go}, 32'h2);
    chk("R7 cmd word", cmd_word, 32'h0022_1005);
    rd_chk("R7 busy set", 7'h16, 32'h0200_1002);
    rd_chk("R9 data ones", 7'h04, 32'hFFFF_FFFF);
    rd_chk("R9 busy error", 7'h16, 32'h0200_1102);
    wr(7'h04, 32'h0000_1234);
    wr(7'h16, 32'h0000_0700);
    wr(7'h20, 32'h0000_DEAD);
    rd_chk("R10 prog ones", 7'h20, 32'hFFFF_FFFF);
    rd_chk("R10 no error", 7'h16, 32'h0200_1002);
    pulse_done(2);
    rd_chk("R7 other hart done", 7'h16, 32'h0200_1002);
    pulse_done(1);
    rd_chk("R7 busy cleared", 7'h16, 32'h0200_0002);
    rd_chk("R9 data kept", 7'h04, 32'hA5A5_0001);
    rd_chk("R10 prog kept", 7'h20, 32'h0000_0013);
  endtask

  task automatic t_auto();
    wr(7'h18, 32'h0001_0002);
    rd_chk("R11 masks", 7'h18, 32'h0001_0002);
    acc(1'b0, 7'h05, 32'h0);
    chk("R11 data1 relaunch", {28'b0, r_go}, 32'h2);
    pulse_done(1);
    wr(7'h04, 32'h0000_0077);
    chk("R11 data0 no launch", {28'b0, r_go}, 32'h0);
    acc(1'b0, 7'h20, 32'h0);
    chk("R11 prog0 relaunch", {28'b0, r_go}, 32'h2);
    acc(1'b0, 7'h05, 32'h0);
    chk("R11 no relaunch busy", {28'b0, r_go}, 32'h0);
    pulse_done(1);
    acc(1'b0, 7'h21, 32'h0);
    chk("R11 prog1 no launch", {28'b0, r_go}, 32'h0);
  endtask

  task automatic t_misc();
    acc(1'b0, 7'h7F, 32'h0);
    chk("R12 unmapped err", {31'b0, r_err}, 32'd1);
    wr(7'h11, 32'h0);
    chk("R12 status write err", {31'b0, r_err}, 32'd1);
    acc(1'b0, 7'h17, 32'h0);
    chk("R12 command reads 0", r_data, 32'h0);
    chk("R12 command no err", {31'b0, r_err}, 32'd0);
    wr(7'h17, 32'h0022_1005);
    wr(7'h10, 32'h0);
    rd_chk("R2 busy and err cleared", 7'h16, 32'h0200_0002);
    rd_chk("R2 autoexec zero", 7'h18, 32'h0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    rst_ni = 1'b0; req = 1'b0; we = 1'b0; addr = '0; wdata = '0;
    halted = '0; rack = '0; done = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_ni = 1'b1;
    repeat (4) @(posedge clk);
    t_reset();
    t_control();
    t_status();
    t_resume();
    t_cmd_err();
    t_busy();
    t_auto();
    t_misc();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule